// File: doc/BRIEF.md
# Snooping Cache DMA Responder

This block is a small direct-mapped write-back cache for a processor. It also keeps its contents coherent with a DMA engine that shares the system bus with main memory. The cache holds one 32-bit word per line, with a valid bit and a dirty bit for each line. It serves processor loads and stores through a port that accepts one request per cycle. A miss in the cache is resolved in the same cycle through a memory read channel and a memory write channel. The read channel fills the line, and the write channel writes back a dirty victim.

A snoop port watches every DMA transaction on the shared bus. When the DMA engine reads a word that the cache holds in modified form, the cache raises an inhibit signal. Memory stays off the bus, and the cache drives its own copy, so the device never receives a stale word. When the DMA engine writes a word into memory, the cache acts on a matching line according to a policy input. The line is either dropped, or overwritten with the bus data and marked clean, because memory takes the same write.

A snoop always has priority over the processor. In a cycle with bus activity the processor port is not ready, and a held request is served in the first quiet cycle.

Top module: `dma_snoop_cache`

## Requirements
- R1: After reset every line is invalid and cpu_rvalid and snoop_inhibit are low. The first processor read of any address is therefore a miss, and a DMA read finds no line.
- R2: A processor request is accepted in a cycle where cpu_req and cpu_ready are both high. cpu_rvalid is high in the following cycle. For a read, cpu_rdata then holds the current word of that address. For a write, cpu_rdata holds the written word.
- R3: A read miss asserts mem_rd_en with mem_rd_addr equal to the request address in the acceptance cycle. The line is filled clean with mem_rd_data.
- R4: A write hit updates the line and marks it dirty, with no memory traffic. A write miss allocates the line as dirty without asserting mem_rd_en.
- R5: An accepted miss whose line holds a valid dirty word of another address asserts mem_wr_en in the acceptance cycle. The address is {old tag, line index}, where the index is the low 4 address bits and the tag is the upper bits, and the data is the old word. A clean or invalid victim causes no memory write.
- R6: A DMA read (bus_valid=1, bus_we=0) of an address held dirty raises snoop_inhibit in the same cycle, with snoop_rdata equal to the cached word.
- R7: A DMA read that misses, or that hits a clean line, leaves snoop_inhibit low and snoop_rdata zero, so memory answers.
- R8: With upd_mode=0, a DMA write (bus_valid=1, bus_we=1) to a cached address invalidates that line, dirty or not. A later processor read of that address refetches from memory.
- R9: With upd_mode=1, a DMA write to a cached address replaces the line data with bus_wdata and leaves the line valid and clean. The line later causes no write-back.
- R10: A DMA write to an address not in the cache changes no line, including a valid line at the same index with another tag.
- R11: cpu_ready is low in every cycle with bus_valid high. No memory traffic is issued for the processor in such a cycle, and a held request completes once the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_mode | input | 1 | Snoop write policy: 1 update line, 0 invalidate line |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | 8 | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ready | output | 1 | Request can be accepted this cycle |
| cpu_rvalid | output | 1 | Response valid, one cycle after acceptance |
| cpu_rdata | output | 32 | Response word |
| mem_rd_en | output | 1 | Fill read from memory this cycle |
| mem_rd_addr | output | 8 | Fill address |
| mem_rd_data | input | 32 | Fill data, combinational from memory |
| mem_wr_en | output | 1 | Victim write-back this cycle |
| mem_wr_addr | output | 8 | Write-back address |
| mem_wr_data | output | 32 | Write-back data |
| bus_valid | input | 1 | DMA transaction on the shared bus |
| bus_we | input | 1 | DMA transaction writes memory |
| bus_addr | input | 8 | DMA word address |
| bus_wdata | input | 32 | DMA write data |
| snoop_inhibit | output | 1 | Cache supplies the DMA read; memory must not drive |
| snoop_rdata | output | 32 | Cache-supplied DMA read data |

## Verification
The bench goes after dirty lines that meet DMA traffic. A design that ignored the dirty bit on a DMA read would hand the device the stale memory word. One that left the line dirty after an update would later write back a word memory already has. Aliasing tags at one index are driven on purpose. A snoop that compared only the index would wrongly inhibit or invalidate another address's line. Same-cycle collisions check that a stalled request is neither lost nor served twice, and that no fill or write-back leaks into a snoop cycle.

// File: rtl/snc_pkg.sv
package snc_pkg;

  typedef enum logic [1:0] {
    SNP_IDLE = 2'd0,
    SNP_READ = 2'd1,
    SNP_WRITE = 2'd2
  } snp_kind_e;

  function automatic snp_kind_e snp_classify(input logic valid, input logic we);
    if (!valid) return SNP_IDLE;
    return we ? SNP_WRITE : SNP_READ;
  endfunction

endpackage

// File: rtl/snc_store.sv
module snc_store #(
  parameter int LINES  = 16,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  a_idx,
  output logic              a_valid,
  output logic              a_dirty,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output logic              b_valid,
  output logic              b_dirty,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  output logic [LINES-1:0]  valid_vec,
  output logic [LINES-1:0]  dirty_vec
);

  logic [LINES-1:0]  valid_q, dirty_q, line_we;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign line_we[g] = wr_en && (wr_idx == IDX_W'(g));

    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q[g] |-> valid_q[g]); // R5
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (line_we[i]) begin
          valid_q[i] <= wr_valid;
          dirty_q[i] <= wr_dirty;
          tag_q[i]   <= wr_tag;
          data_q[i]  <= wr_data;
        end
      end
    end
  end

  assign a_valid   = valid_q[a_idx];
  assign a_dirty   = dirty_q[a_idx];
  assign a_tag     = tag_q[a_idx];
  assign a_data    = data_q[a_idx];
  assign b_valid   = valid_q[b_idx];
  assign b_dirty   = dirty_q[b_idx];
  assign b_tag     = tag_q[b_idx];
  assign b_data    = data_q[b_idx];
  assign valid_vec = valid_q;
  assign dirty_vec = dirty_q;

endmodule

// File: rtl/snc_snoop.sv
module snc_snoop
  import snc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              upd_mode,
  input  logic              l_valid,
  input  logic              l_dirty,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic [DATA_W-1:0] l_data,
  output logic              snp_hit,
  output logic              inhibit,
  output logic [DATA_W-1:0] snp_rdata,
  output logic              wr_en,
  output logic              wr_valid,
  output logic              wr_dirty,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  snp_kind_e kind;

  always_comb begin
    kind      = snp_classify(bus_valid, bus_we);
    snp_hit   = (kind != SNP_IDLE) && l_valid && (l_tag == tag_of(bus_addr));
    inhibit   = (kind == SNP_READ) && snp_hit && l_dirty;
    snp_rdata = inhibit ? l_data : '0;
    wr_en     = (kind == SNP_WRITE) && snp_hit;
    wr_valid  = upd_mode;
    wr_dirty  = 1'b0;
    wr_tag    = l_tag;
    wr_data   = upd_mode ? bus_wdata : l_data;
  end

endmodule

// File: rtl/snc_cpu.sv
module snc_cpu #(
  parameter int ADDR_W = 8,
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              l_valid,
  input  logic              l_dirty,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic [DATA_W-1:0] l_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              wr_en,
  output logic              wr_valid,
  output logic              wr_dirty,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i};
  endfunction

  logic              accept, hit, victim_dirty;
  logic [DATA_W-1:0] word;

  always_comb begin
    accept       = cpu_req && !stall;
    hit          = l_valid && (l_tag == tag_of(cpu_addr));
    victim_dirty = l_valid && l_dirty && !hit;
    word         = hit ? l_data : mem_rd_data;

    mem_wr_en    = accept && victim_dirty;
    mem_wr_addr  = join_addr(l_tag, idx_of(cpu_addr));
    mem_wr_data  = l_data;
    mem_rd_en    = accept && !cpu_we && !hit;
    mem_rd_addr  = cpu_addr;

    wr_en        = accept && (cpu_we || !hit);
    wr_valid     = 1'b1;
    wr_dirty     = cpu_we;
    wr_tag       = tag_of(cpu_addr);
    wr_data      = cpu_we ? cpu_wdata : mem_rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      cpu_rvalid <= accept;
      if (accept) cpu_rdata <= cpu_we ? cpu_wdata : word;
    end
  end

  AST_WB_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_wr_addr != cpu_addr)); // R5
  AST_NO_FILL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !cpu_we); // R4

endmodule

// File: rtl/dma_snoop_cache.sv
module dma_snoop_cache #(
  parameter int ADDR_W = 8,
  parameter int LINES  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_mode,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              snoop_inhibit,
  output logic [DATA_W-1:0] snoop_rdata
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              a_valid, a_dirty, b_valid, b_dirty;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;
  logic [LINES-1:0]  valid_vec, dirty_vec;

  logic              c_wr_en, c_wr_valid, c_wr_dirty;
  logic [TAG_W-1:0]  c_wr_tag;
  logic [DATA_W-1:0] c_wr_data;
  logic              s_wr_en, s_wr_valid, s_wr_dirty, snp_hit;
  logic [TAG_W-1:0]  s_wr_tag;
  logic [DATA_W-1:0] s_wr_data;

  logic              st_en, st_valid, st_dirty;
  logic [IDX_W-1:0]  st_idx, cpu_idx, bus_idx;
  logic [TAG_W-1:0]  st_tag;
  logic [DATA_W-1:0] st_data;

  assign cpu_idx   = cpu_addr[IDX_W-1:0];
  assign bus_idx   = bus_addr[IDX_W-1:0];
  assign cpu_ready = !bus_valid;

  always_comb begin
    if (s_wr_en) begin
      st_en = 1'b1; st_idx = bus_idx; st_valid = s_wr_valid;
      st_dirty = s_wr_dirty; st_tag = s_wr_tag; st_data = s_wr_data;
    end else begin
      st_en = c_wr_en; st_idx = cpu_idx; st_valid = c_wr_valid;
      st_dirty = c_wr_dirty; st_tag = c_wr_tag; st_data = c_wr_data;
    end
  end

  snc_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(st_en), .wr_idx(st_idx), .wr_valid(st_valid), .wr_dirty(st_dirty),
    .wr_tag(st_tag), .wr_data(st_data),
    .a_idx(cpu_idx), .a_valid(a_valid), .a_dirty(a_dirty), .a_tag(a_tag), .a_data(a_data),
    .b_idx(bus_idx), .b_valid(b_valid), .b_dirty(b_dirty), .b_tag(b_tag), .b_data(b_data),
    .valid_vec(valid_vec), .dirty_vec(dirty_vec)
  );

  snc_cpu #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_cpu (
    .clk(clk), .rst_n(rst_n), .stall(bus_valid),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .l_valid(a_valid), .l_dirty(a_dirty), .l_tag(a_tag), .l_data(a_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .wr_en(c_wr_en), .wr_valid(c_wr_valid), .wr_dirty(c_wr_dirty),
    .wr_tag(c_wr_tag), .wr_data(c_wr_data)
  );

  snc_snoop #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_snoop (
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .upd_mode(upd_mode),
    .l_valid(b_valid), .l_dirty(b_dirty), .l_tag(b_tag), .l_data(b_data),
    .snp_hit(snp_hit), .inhibit(snoop_inhibit), .snp_rdata(snoop_rdata),
    .wr_en(s_wr_en), .wr_valid(s_wr_valid), .wr_dirty(s_wr_dirty),
    .wr_tag(s_wr_tag), .wr_data(s_wr_data)
  );

  logic [IDX_W-1:0] snp_idx_q;
  always_ff @(posedge clk) begin
    if (!rst_n) snp_idx_q <= '0;
    else        snp_idx_q <= bus_idx;
  end

  AST_INHIBIT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_inhibit |-> (bus_valid && !bus_we)); // R6
  AST_NO_MEM_IN_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> !bus_valid); // R11
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready) |=> cpu_rvalid); // R2
  AST_INVALIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && !upd_mode && snp_hit) |=> !valid_vec[snp_idx_q]); // R8
  AST_UPDATE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && upd_mode && snp_hit)
      |=> (valid_vec[snp_idx_q] && !dirty_vec[snp_idx_q])); // R9

endmodule

// File: tb/tb_dma_snoop_cache.sv
module tb_dma_snoop_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_mode = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_rd_en, mem_wr_en;
  logic [7:0]  mem_rd_addr, mem_wr_addr;
  logic [31:0] mem_rd_data, mem_wr_data;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        snoop_inhibit;
  logic [31:0] snoop_rdata;

  always #2 clk = ~clk;

  dma_snoop_cache dut (
    .clk(clk), .rst_n(rst_n), .upd_mode(upd_mode),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .snoop_inhibit(snoop_inhibit), .snoop_rdata(snoop_rdata)
  );

  // environment memory, written by write-backs and DMA writes
  logic [31:0] sys_mem [256];
  assign mem_rd_data = sys_mem[mem_rd_addr];
  always @(posedge clk) begin
    if (mem_wr_en) sys_mem[mem_wr_addr] <= mem_wr_data;
    if (bus_valid && bus_we) sys_mem[bus_addr] <= bus_wdata;
  end

  // reference model
  bit          m_v [16];
  bit          m_d [16];
  int          m_t [16];
  logic [31:0] m_w [16];
  logic [31:0] ref_mem [256];
  bit          exp_rvalid;
  logic [31:0] exp_rdata;
  string       cur_req = "R1";

  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit creq, input bit cwe, input logic [7:0] caddr,
                      input logic [31:0] cwd, input bit bv, input bit bwe,
                      input logic [7:0] baddr, input logic [31:0] bwd, input bit um);
    int ci, ct, bi, bt;
    bit acc, chit, bhit, ewb, erd, einh;
    logic [31:0] word, coherent, seen;
    @(negedge clk);
    cpu_req = creq; cpu_we = cwe; cpu_addr = caddr; cpu_wdata = cwd;
    bus_valid = bv; bus_we = bwe; bus_addr = baddr; bus_wdata = bwd; upd_mode = um;
    #1;
    ci = caddr % 16; ct = caddr / 16; bi = baddr % 16; bt = baddr / 16;
    acc  = creq && !bv;
    chit = m_v[ci] && (m_t[ci] == ct);
    bhit = m_v[bi] && (m_t[bi] == bt);
    ewb  = acc && m_v[ci] && m_d[ci] && !chit;
    erd  = acc && !cwe && !chit;
    einh = bv && !bwe && bhit && m_d[bi];

    chk(cur_req, "cpu_rvalid", {31'd0, cpu_rvalid}, {31'd0, exp_rvalid});
    if (exp_rvalid) chk(cur_req, "cpu_rdata", cpu_rdata, exp_rdata);
    chk("R11", "cpu_ready", {31'd0, cpu_ready}, {31'd0, !bv});
    chk(cur_req, "mem_wr_en", {31'd0, mem_wr_en}, {31'd0, ewb});
    if (ewb) begin
      chk("R5", "mem_wr_addr", {24'd0, mem_wr_addr}, 32'(m_t[ci] * 16 + ci));
      chk("R5", "mem_wr_data", mem_wr_data, m_w[ci]);
    end
    chk(cur_req, "mem_rd_en", {31'd0, mem_rd_en}, {31'd0, erd});
    if (erd) chk("R3", "mem_rd_addr", {24'd0, mem_rd_addr}, {24'd0, caddr});
    chk(cur_req, "snoop_inhibit", {31'd0, snoop_inhibit}, {31'd0, einh});
    chk(cur_req, "snoop_rdata", snoop_rdata, einh ? m_w[bi] : 32'd0);
    if (bv && !bwe) begin
      coherent = bhit ? m_w[bi] : ref_mem[baddr];
      seen = snoop_inhibit ? snoop_rdata : sys_mem[baddr];
      chk("R6", "dma read word", seen, coherent);
    end

    // advance model
    exp_rvalid = acc;
    if (acc) begin
      word = chit ? m_w[ci] : ref_mem[caddr];
      if (ewb) ref_mem[m_t[ci] * 16 + ci] = m_w[ci];
      if (cwe) begin
        m_v[ci] = 1; m_d[ci] = 1; m_t[ci] = ct; m_w[ci] = cwd; exp_rdata = cwd;
      end else begin
        if (!chit) begin m_v[ci] = 1; m_d[ci] = 0; m_t[ci] = ct; m_w[ci] = word; end
        exp_rdata = word;
      end
    end
    if (bv && bwe) begin
      ref_mem[baddr] = bwd;
      if (bhit) begin
        if (um) begin m_w[bi] = bwd; m_d[bi] = 0; end
        else begin m_v[bi] = 0; m_d[bi] = 0; end
      end
    end
  endtask

  task automatic cpu(input bit we, input logic [7:0] a, input logic [31:0] d);
    step(1, we, a, d, 0, 0, 8'd0, 32'd0, upd_mode);
  endtask

  task automatic dma(input bit we, input logic [7:0] a, input logic [31:0] d, input bit um);
    step(0, 0, 8'd0, 32'd0, 1, we, a, d, um);
  endtask

  task automatic idle();
    step(0, 0, 8'd0, 32'd0, 0, 0, 8'd0, 32'd0, upd_mode);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      sys_mem[i] = 32'hC0DE0000 ^ (i * 32'h00010F03);
      ref_mem[i] = sys_mem[i];
    end
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 0; m_d[i] = 0; m_t[i] = 0; m_w[i] = '0;
    end
    exp_rvalid = 0; exp_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "rvalid in reset", {31'd0, cpu_rvalid}, 32'd0);
    chk("R1", "inhibit in reset", {31'd0, snoop_inhibit}, 32'd0);
    rst_n = 1'b1;

    // R1: nothing cached after reset
    cur_req = "R1";
    for (int i = 0; i < 16; i++) dma(0, 8'(i), 32'd0, 0);
    cpu(0, 8'h03, 0);

    // R3 fill then R2 hit
    cur_req = "R3";
    cpu(0, 8'h05, 0);
    cur_req = "R2";
    cpu(0, 8'h05, 0);
    cpu(0, 8'h03, 0);

    // R4 write hit and write miss
    cur_req = "R4";
    cpu(1, 8'h05, 32'h11112222);
    cpu(1, 8'h26, 32'h33334444);
    cpu(0, 8'h26, 0);
    cpu(0, 8'h05, 0);

    // R5 dirty victims written back, clean victim not
    cur_req = "R5";
    cpu(0, 8'h36, 0);
    cpu(0, 8'h15, 0);
    cpu(0, 8'h46, 0);
    cpu(0, 8'h26, 0);

    // R6 dirty DMA read is supplied by the cache
    cur_req = "R6";
    cpu(1, 8'h47, 32'hDEADBEEF);
    dma(0, 8'h47, 0, 0);
    dma(0, 8'h47, 0, 1);

    // R7 clean hit and miss leave memory to answer
    cur_req = "R7";
    dma(0, 8'h26, 0, 0);
    dma(0, 8'h99, 0, 0);
    dma(0, 8'h57, 0, 0);

    // R8 invalidate policy
    cur_req = "R8";
    cpu(1, 8'h48, 32'hAAAA5555);
    dma(1, 8'h48, 32'h0BADF00D, 0);
    cpu(0, 8'h48, 0);
    cpu(0, 8'h5A, 0);
    dma(1, 8'h5A, 32'h12340000, 0);
    cpu(0, 8'h5A, 0);

    // R9 update policy leaves line clean
    cur_req = "R9";
    cpu(0, 8'h6B, 0);
    dma(1, 8'h6B, 32'h76543210, 1);
    cpu(0, 8'h6B, 0);
    cpu(1, 8'h4C, 32'hFACEFACE);
    dma(1, 8'h4C, 32'h5EED5EED, 1);
    dma(0, 8'h4C, 0, 1);
    cpu(0, 8'h5C, 0);
    cpu(0, 8'h4C, 0);

    // R10 DMA write miss with same index, other tag
    cur_req = "R10";
    cpu(1, 8'h1D, 32'h01020304);
    dma(1, 8'h2D, 32'h99999999, 1);
    dma(1, 8'h3D, 32'h88888888, 0);
    dma(0, 8'h1D, 0, 0);
    cpu(0, 8'h1D, 0);

    // R11 collision: snoop first, request held and served after
    cur_req = "R11";
    step(1, 0, 8'h7E, 0, 1, 0, 8'h1D, 0, 0);
    step(1, 0, 8'h7E, 0, 1, 1, 8'h1D, 32'h13572468, 1);
    step(1, 0, 8'h7E, 0, 0, 0, 8'h00, 0, 1);
    step(1, 1, 8'h8E, 32'h24681357, 1, 0, 8'h7E, 0, 1);
    step(1, 1, 8'h8E, 32'h24681357, 0, 0, 8'h00, 0, 1);
    dma(0, 8'h8E, 0, 1);

    // mixed traffic
    cur_req = "R2";
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], {2'b00, r[13:8]}, $urandom, r[2] & r[3], r[4],
           {2'b00, r[21:16]}, $urandom, r[5]);
    end
    idle();
    idle();
    summary();
  end

endmodule